// File: doc/BRIEF.md
# GF(16) Pattern-Matching Logarithm Array

This block turns nonzero elements of GF(2^4) into their discrete logarithms (exponents of the primitive element alpha) by comparing them against stored patterns. It also turns an exponent back into an element. It is a linear systolic pipeline of processing elements (PEs). Each PE holds one base pattern alpha^(4n), the subset index n of that pattern, and a bit that selects the field polynomial. All three are written through a configuration port before any work starts.

On the forward path two operands travel through every PE together with an operation bit. Each PE has four pipeline stages. In stage k, each operand is compared with the base pattern after k circle rotations (multiplications by alpha). The first match records the exponent. The reverse path runs through the PEs in the opposite order, one cycle per PE. It carries a result power, a valid flag and an intermediate-pattern bus. The PE whose subset index equals the upper bits of the result power puts its base pattern on that bus. Exponent arithmetic and the final rotation by the low power bits sit outside this block. Both paths accept a new entry every cycle and run independently of each other.

Top module: `gflog_array`

## Requirements
- R1: A synchronous active-high reset clears every forward output and every reverse output to zero on the next clock edge.
- R2: An operation bit presented on `op_in` appears on `op_o` exactly N_PE*N_STG clock edges later (16 by default).
- R3: With every PE configured for polynomial x^4+x+1 (select bit 0) and PE n loaded with pattern alpha^(4n) and index n, a nonzero operand alpha^e gives hit 1 and exponent e 16 edges later. The exponent is encoded as {index[1:0], k[1:0]}, where k is the stage (0..3) in which the match happened.
- R4: The same holds with every PE configured for x^4+x^3+1 (select bit 1) and loaded with that field's powers of alpha.
- R5: Once an operand has matched, later matches are ignored. The element 1, which matches again at rotation 3 of the last PE, therefore reports exponent 0, not 15.
- R6: An operand of value 0 never matches. It leaves with hit 0 and exponent 0.
- R7: The second operand is resolved independently of the first, in the same cycles, with the same encoding.
- R8: A new operand pair is accepted every cycle. Consecutive pairs each produce their own result in their own output cycle.
- R9: A reverse entry with the valid flag set leaves 4 (N_PE) edges later. Its pattern bus then holds the base pattern of the PE whose index equals bits [3:2] of the result power.
- R10: A reverse entry with the valid flag clear leaves with pattern 0. The result power and the valid flag leave unchanged, with the same latency as in R9.
- R11: A configuration write changes only the PE addressed by `cfg_sel`. Reverse lookups in other PEs still return their old patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Index of the PE to write |
| cfg_pat | input | 4 | Base pattern to store |
| cfg_idx | input | 2 | Subset index (upper power bits) to store |
| cfg_poly | input | 1 | Polynomial select: 0 = x^4+x+1, 1 = x^4+x^3+1 |
| x_in | input | 4 | First operand |
| y_in | input | 4 | Second operand |
| op_in | input | 1 | Operation bit carried alongside the operands |
| x_exp_o | output | 4 | Exponent of the first operand |
| y_exp_o | output | 4 | Exponent of the second operand |
| x_hit_o | output | 1 | First operand was recognised |
| y_hit_o | output | 1 | Second operand was recognised |
| op_o | output | 1 | Delayed operation bit |
| rp_in | input | 4 | Result power entering the reverse path |
| rp_valid_in | input | 1 | Valid flag for the result power |
| rp_o | output | 4 | Result power leaving the reverse path |
| rp_valid_o | output | 1 | Valid flag leaving the reverse path |
| res_pat_o | output | 4 | Intermediate pattern selected on the reverse path |

## Verification
Forward recognition and reverse lookup share the same PEs and the same configuration registers, so they can be active in the same cycle. The bench provokes this by feeding a fresh operand pair and a fresh reverse request on every cycle of a table walk, so each PE is busy with both at once. Each stream is judged against its own expected value at its own latency: 16 edges for the exponents and 4 for the pattern. A reverse request that disturbed a forward result, or the other way round, would show as a mismatch in one of the two streams. The walk is repeated under both polynomials.

// File: rtl/gflog_pkg.sv
package gflog_pkg;

  localparam int FW = 4;

  typedef logic [FW-1:0] elem_t;

  // low-order taps of the two selectable field polynomials
  localparam elem_t TAPS_A = 4'b0011;  // x^4 + x + 1
  localparam elem_t TAPS_B = 4'b1001;  // x^4 + x^3 + 1

  // multiply by alpha: shift left, fold the carry back through the taps
  function automatic elem_t alpha_step(elem_t b, logic sel);
    elem_t taps;
    taps = sel ? TAPS_B : TAPS_A;
    return {b[FW-2:0], 1'b0} ^ (b[FW-1] ? taps : '0);
  endfunction

  typedef struct packed {
    elem_t x;
    elem_t y;
    logic  op;
    elem_t xe;
    elem_t ye;
    logic  xh;
    logic  yh;
  } fwd_t;

  typedef struct packed {
    elem_t rp;
    logic  rv;
    elem_t pat;
  } rev_t;

endpackage

// File: rtl/gflog_fwd_stage.sv
module gflog_fwd_stage
  import gflog_pkg::*;
#(
  parameter int STG = 0,
  parameter int K_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  elem_t             pat,
  input  logic [FW-K_W-1:0] idx,
  input  fwd_t              d,
  output fwd_t              q
);

  fwd_t  nxt;
  elem_t code;

  assign code = {idx, K_W'(STG)};

  always_comb begin
    nxt = d;
    if (!d.xh && (d.x != '0) && (d.x == pat)) begin
      nxt.xh = 1'b1;
      nxt.xe = code;
    end
    if (!d.yh && (d.y != '0) && (d.y == pat)) begin
      nxt.yh = 1'b1;
      nxt.ye = code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R5: a recognised operand keeps its exponent
  p_sticky_hit_r5: assert property (@(posedge clk) disable iff (rst)
    d.xh |=> (q.xh && q.xe == $past(d.xe)));
  p_sticky_hit_y_r5: assert property (@(posedge clk) disable iff (rst)
    d.yh |=> (q.yh && q.ye == $past(d.ye)));

  // R6: zero is never recognised
  p_zero_nomatch_r6: assert property (@(posedge clk) disable iff (rst)
    (d.x == '0 && !d.xh) |=> !q.xh);

  // R3: a new hit carries this stage's rotation count in the low bits
  p_new_hit_low_bits_r3: assert property (@(posedge clk) disable iff (rst)
    !d.xh |=> (!q.xh || q.xe[K_W-1:0] == K_W'(STG)));

endmodule

// File: rtl/gflog_rev_cell.sv
module gflog_rev_cell
  import gflog_pkg::*;
#(
  parameter int K_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  elem_t             pat,
  input  logic [FW-K_W-1:0] idx,
  input  rev_t              r_in,
  output rev_t              r_out
);

  logic hit;

  assign hit = r_in.rv && (r_in.rp[FW-1:K_W] == idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_out <= '0;
    end else begin
      r_out.rp  <= r_in.rp;
      r_out.rv  <= r_in.rv;
      r_out.pat <= hit ? pat : r_in.pat;
    end
  end

  // R10: an invalid entry leaves the pattern bus untouched
  p_rev_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !r_in.rv |=> (r_out.pat == $past(r_in.pat)));

  // R9: power and valid flag travel with the entry
  p_rev_carry_r9: assert property (@(posedge clk) disable iff (rst)
    r_in.rv |=> (r_out.rv && r_out.rp == $past(r_in.rp)));

endmodule

// File: rtl/gflog_pe.sv
module gflog_pe
  import gflog_pkg::*;
#(
  parameter int N_STG  = 4,
  parameter int K_W    = 2,
  parameter int PE_W   = 2,
  parameter int PE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [PE_W-1:0]   cfg_sel,
  input  elem_t             cfg_pat,
  input  logic [FW-K_W-1:0] cfg_idx,
  input  logic              cfg_poly,
  input  fwd_t              f_in,
  output fwd_t              f_out,
  input  rev_t              r_in,
  output rev_t              r_out
);

  elem_t             pat_q;
  logic [FW-K_W-1:0] idx_q;
  logic              poly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q  <= '0;
      idx_q  <= '0;
      poly_q <= 1'b0;
    end else if (cfg_we && cfg_sel == PE_W'(PE_IDX)) begin
      pat_q  <= cfg_pat;
      idx_q  <= cfg_idx;
      poly_q <= cfg_poly;
    end
  end

  // base pattern rotated once per stage
  elem_t rot  [N_STG];
  fwd_t  link [N_STG+1];

  assign rot[0]  = pat_q;
  assign link[0] = f_in;

  for (genvar s = 1; s < N_STG; s++) begin : g_rot
    assign rot[s] = alpha_step(rot[s-1], poly_q);
  end

  for (genvar s = 0; s < N_STG; s++) begin : g_stage
    gflog_fwd_stage #(
      .STG (s),
      .K_W (K_W)
    ) u_stage (
      .clk (clk),
      .rst (rst),
      .pat (rot[s]),
      .idx (idx_q),
      .d   (link[s]),
      .q   (link[s+1])
    );
  end

  assign f_out = link[N_STG];

  gflog_rev_cell #(
    .K_W (K_W)
  ) u_rev (
    .clk   (clk),
    .rst   (rst),
    .pat   (pat_q),
    .idx   (idx_q),
    .r_in  (r_in),
    .r_out (r_out)
  );

endmodule

// File: rtl/gflog_array.sv
module gflog_array
  import gflog_pkg::*;
#(
  parameter int N_PE  = 4,
  parameter int N_STG = 4,
  localparam int K_W  = $clog2(N_STG),
  localparam int PE_W = $clog2(N_PE),
  localparam int IX_W = FW - K_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [PE_W-1:0] cfg_sel,
  input  logic [FW-1:0]   cfg_pat,
  input  logic [IX_W-1:0] cfg_idx,
  input  logic            cfg_poly,
  input  logic [FW-1:0]   x_in,
  input  logic [FW-1:0]   y_in,
  input  logic            op_in,
  output logic [FW-1:0]   x_exp_o,
  output logic [FW-1:0]   y_exp_o,
  output logic            x_hit_o,
  output logic            y_hit_o,
  output logic            op_o,
  input  logic [FW-1:0]   rp_in,
  input  logic            rp_valid_in,
  output logic [FW-1:0]   rp_o,
  output logic            rp_valid_o,
  output logic [FW-1:0]   res_pat_o
);

  fwd_t fchain [N_PE+1];
  rev_t rchain [N_PE+1];
  fwd_t f_head;
  rev_t r_tail;

  always_comb begin
    f_head    = '0;
    f_head.x  = x_in;
    f_head.y  = y_in;
    f_head.op = op_in;
    r_tail    = '0;
    r_tail.rp = rp_in;
    r_tail.rv = rp_valid_in;
  end

  assign fchain[0]    = f_head;
  assign rchain[N_PE] = r_tail;

  for (genvar p = 0; p < N_PE; p++) begin : g_pe
    gflog_pe #(
      .N_STG  (N_STG),
      .K_W    (K_W),
      .PE_W   (PE_W),
      .PE_IDX (p)
    ) u_pe (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_pat  (cfg_pat),
      .cfg_idx  (cfg_idx),
      .cfg_poly (cfg_poly),
      .f_in     (fchain[p]),
      .f_out    (fchain[p+1]),
      .r_in     (rchain[p+1]),
      .r_out    (rchain[p])
    );
  end

  assign x_exp_o    = fchain[N_PE].xe;
  assign y_exp_o    = fchain[N_PE].ye;
  assign x_hit_o    = fchain[N_PE].xh;
  assign y_hit_o    = fchain[N_PE].yh;
  assign op_o       = fchain[N_PE].op;
  assign rp_o       = rchain[0].rp;
  assign rp_valid_o = rchain[0].rv;
  assign res_pat_o  = rchain[0].pat;

  // R6: an unrecognised operand leaves with a zero exponent
  p_miss_zero_exp_r6: assert property (@(posedge clk) disable iff (rst)
    (!x_hit_o |-> x_exp_o == '0) and (!y_hit_o |-> y_exp_o == '0));

  // R10: an invalid reverse entry leaves with an empty pattern
  p_rev_empty_r10: assert property (@(posedge clk) disable iff (rst)
    !rp_valid_o |-> res_pat_o == '0);

endmodule

// File: tb/gflog_array_tb.sv
module gflog_array_tb;

  localparam int LAT_F = 16;
  localparam int LAT_R = 4;
  localparam int NV    = 16;

  // vector fields: [13] op, [12:9] x, [8:5] y, [4:1] result power, [0] valid
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 4'd2,  4'd3,  4'd0,  1'b1},
    {1'b1, 4'd1,  4'd1,  4'd4,  1'b1},
    {1'b0, 4'd0,  4'd5,  4'd8,  1'b1},
    {1'b1, 4'd9,  4'd0,  4'd12, 1'b1},
    {1'b0, 4'd15, 4'd14, 4'd15, 1'b0},
    {1'b0, 4'd7,  4'd8,  4'd3,  1'b1},
    {1'b1, 4'd12, 4'd6,  4'd7,  1'b1},
    {1'b0, 4'd13, 4'd11, 4'd13, 1'b1},
    {1'b1, 4'd4,  4'd10, 4'd0,  1'b0},
    {1'b0, 4'd1,  4'd15, 4'd14, 1'b1},
    {1'b1, 4'd6,  4'd2,  4'd5,  1'b1},
    {1'b0, 4'd11, 4'd0,  4'd9,  1'b1},
    {1'b0, 4'd0,  4'd0,  4'd2,  1'b0},
    {1'b1, 4'd8,  4'd12, 4'd11, 1'b1},
    {1'b0, 4'd5,  4'd7,  4'd6,  1'b1},
    {1'b1, 4'd10, 4'd13, 4'd1,  1'b1}
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [3:0] cfg_pat;
  logic [1:0] cfg_idx;
  logic       cfg_poly;
  logic [3:0] x_in, y_in;
  logic       op_in;
  logic [3:0] x_exp_o, y_exp_o;
  logic       x_hit_o, y_hit_o, op_o;
  logic [3:0] rp_in;
  logic       rp_valid_in;
  logic [3:0] rp_o;
  logic       rp_valid_o;
  logic [3:0] res_pat_o;

  always #5 clk = ~clk;

  gflog_array u_dut (
    .clk (clk), .rst (rst),
    .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_pat (cfg_pat),
    .cfg_idx (cfg_idx), .cfg_poly (cfg_poly),
    .x_in (x_in), .y_in (y_in), .op_in (op_in),
    .x_exp_o (x_exp_o), .y_exp_o (y_exp_o),
    .x_hit_o (x_hit_o), .y_hit_o (y_hit_o), .op_o (op_o),
    .rp_in (rp_in), .rp_valid_in (rp_valid_in),
    .rp_o (rp_o), .rp_valid_o (rp_valid_o), .res_pat_o (res_pat_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [3:0] pw [2][15];
  logic [3:0] lg [2][16];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    x_in = 0; y_in = 0; op_in = 0; rp_in = 0; rp_valid_in = 0;
  endtask

  task automatic cfg_write(input int sel, input logic [3:0] pat, input int idx, input logic poly);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_pat = pat; cfg_idx = 2'(idx); cfg_poly = poly;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load_field(input int ps);
    for (int n = 0; n < 4; n++) cfg_write(n, pw[ps][4*n], n, 1'(ps));
  endtask

  task automatic run_table(input int ps);
    for (int t = 0; t < NV + LAT_F; t++) begin
      @(negedge clk);
      if (t >= LAT_F) begin
        logic [13:0] v;
        logic [3:0] xv, yv;
        v  = VEC[t-LAT_F];
        xv = v[12:9];
        yv = v[8:5];
        chk(xv == 0 ? "R6 x hit" : (xv == 1 ? "R5 x hit" : (ps == 1 ? "R4 x hit" : "R3 x hit")),
            8'(x_hit_o), 8'(xv != 0));
        chk(xv == 0 ? "R6 x exp" : (xv == 1 ? "R5 x exp" : (ps == 1 ? "R4 x exp" : "R3 x exp")),
            8'(x_exp_o), xv == 0 ? 8'd0 : 8'(lg[ps][xv]));
        chk("R7 y hit", 8'(y_hit_o), 8'(yv != 0));
        chk("R7 y exp", 8'(y_exp_o), yv == 0 ? 8'd0 : 8'(lg[ps][yv]));
        chk("R2 R8 op", 8'(op_o), 8'(v[13]));
      end
      if (t >= LAT_R && t - LAT_R < NV) begin
        logic [13:0] v;
        v = VEC[t-LAT_R];
        chk(v[0] ? "R9 pattern" : "R10 pattern", 8'(res_pat_o),
            v[0] ? 8'(pw[ps][{v[4:3], 2'b00}]) : 8'd0);
        chk("R10 power", 8'(rp_o), 8'(v[4:1]));
        chk("R10 valid", 8'(rp_valid_o), 8'(v[0]));
      end
      if (t < NV) begin
        op_in = VEC[t][13]; x_in = VEC[t][12:9]; y_in = VEC[t][8:5];
        rp_in = VEC[t][4:1]; rp_valid_in = VEC[t][0];
      end else begin
        idle_inputs();
      end
    end
  endtask

  task automatic rev_probe(input logic [3:0] rp, input logic [3:0] exp);
    @(negedge clk);
    rp_in = rp; rp_valid_in = 1;
    @(negedge clk);
    idle_inputs();
    repeat (LAT_R - 1) @(negedge clk);
    chk("R11 pattern", 8'(res_pat_o), 8'(exp));
  endtask

  task automatic check_zero(input string tag);
    chk(tag, {x_exp_o, y_exp_o}, 8'd0);
    chk(tag, {5'd0, x_hit_o, y_hit_o, op_o}, 8'd0);
    chk(tag, {rp_o, res_pat_o}, 8'd0);
    chk(tag, 8'(rp_valid_o), 8'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // powers of alpha per polynomial, by integer reduction
    for (int ps = 0; ps < 2; ps++) begin
      int v;
      v = 1;
      lg[ps][0] = 0;
      for (int e = 0; e < 15; e++) begin
        pw[ps][e] = 4'(v);
        lg[ps][v] = 4'(e);
        v = v * 2;
        if (v >= 16) v = v ^ (ps == 0 ? 'h13 : 'h19);
      end
    end

    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_pat = 0; cfg_idx = 0; cfg_poly = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check_zero("R1 reset");
    rst = 0;

    load_field(0);
    run_table(0);

    // rewrite PE1 only; PE0 and PE2 keep their patterns
    cfg_write(1, pw[0][5], 1, 1'b0);
    rev_probe(4'd4, pw[0][5]);
    rev_probe(4'd8, pw[0][8]);
    rev_probe(4'd1, pw[0][0]);

    load_field(1);
    run_table(1);

    // reset with the pipeline busy
    @(negedge clk);
    x_in = 4'd3; y_in = 4'd9; op_in = 1; rp_in = 4'd6; rp_valid_in = 1;
    repeat (LAT_F + 2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check_zero("R1 mid-run reset");
    idle_inputs();
    rst = 0;
    @(negedge clk);

    finish_run();
  end

endmodule